// File: doc/BRIEF.md
# Memory-Resident Block Transfer Sequencer

This block moves a block of 12-bit words between a word-addressed main memory and a single device-side word port. It keeps no length or address registers that software programs directly. Both live in two fixed memory words. The word-count location holds minus the number of words to move. The following location holds one less than the first memory address to touch. A start pulse makes the sequencer fetch both words and then move the data one word at a time. When the count reaches zero it stores both updated words back to memory and raises a sticky done flag.

Each memory access is a request (read or write) that the sequencer holds until memory answers with a one-cycle done pulse. The device side uses two valid/ready ports, one for each direction, and a stalled device simply holds the sequencer in place. A 20-bit device-side address is loaded at start and steps by one for every word moved, so the device can follow the position inside its own storage.

Top module: `blk_xfer_seq`

## Requirements
- R1: While rst_n is low, and right after it is released, busy_o, done_o, mem_rd_o, mem_wr_o, dev_rx_ready_o and dev_tx_valid_o are all 0. Asserting rst_n in the middle of a transfer returns the block to this idle state at once.
- R2: After an accepted start pulse, the first memory access is a read of the count location (octal 7750) and the second is a read of the pointer location (octal 7751). Both come before any data access.
- R3: Data access k (counting from 0) uses memory address P+1+k modulo 4096, where P is the value read from the pointer location.
- R4: With dir_wr_i = 0 at start, each word accepted on the dev_rx port is written to memory at the address given by R3, in order of arrival.
- R5: With dir_wr_i = 1 at start, each word is read from memory and offered on dev_tx_data_o. While dev_tx_valid_o is high and dev_tx_ready_i is low, valid stays high and the data does not change.
- R6: When the count location holds C, exactly (4096 - C) mod 4096 words are moved, where a C of 0 means 4096 words. The whole transfer therefore makes exactly that number of data accesses plus four.
- R7: After the last word, the sequencer writes P+n (modulo 4096) to the pointer location and then writes 0 to the count location, in that order.
- R8: done_o rises only on the cycle after memory completes the count write-back. It stays high while the block is idle, and the next accepted start clears it. busy_o is high from the cycle after start until done_o rises.
- R9: dev_addr_o is loaded from dev_addr_i when a start is accepted. It increases by one, modulo 2^20, for each word moved.
- R10: A memory request keeps its kind, address and write data unchanged from the cycle it is raised until the cycle in which mem_done_i is high.
- R11: While the device does not offer data (read direction), the sequencer waits with no timeout. It keeps dev_rx_ready_o high and issues no memory access.
- R12: A start pulse while busy_o is high has no effect on the running transfer, its direction, or dev_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse that begins a transfer when idle |
| dir_wr_i | input | 1 | Direction at start: 0 device to memory, 1 memory to device |
| dev_addr_i | input | 20 | Initial device-side address, loaded at start |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_rdata_i | input | 12 | Memory read data, valid with mem_done_i |
| mem_done_i | input | 1 | One-cycle completion of the pending request |
| dev_rx_valid_i | input | 1 | Device offers a word |
| dev_rx_data_i | input | 12 | Word from the device |
| dev_rx_ready_o | output | 1 | Sequencer accepts a device word |
| dev_tx_valid_o | output | 1 | Sequencer offers a word to the device |
| dev_tx_data_o | output | 12 | Word to the device |
| dev_tx_ready_i | input | 1 | Device accepts the offered word |
| dev_addr_o | output | 20 | Current device-side address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
A corrupted count register shows up at the end of the transfer: the number of data accesses comes out wrong, and the write-back of the count location carries a nonzero value. A pointer error shows up on the very first data access as a wrong address, because the pre-increment happens before that access. A state error that skips a handshake breaks the address or data stability of the pending request within one cycle. A state error that lets done rise early is seen in the same cycle as the count write-back.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GET_CNT,
    ST_GET_PTR,
    ST_DEV_IN,
    ST_MEM_PUT,
    ST_MEM_GET,
    ST_DEV_OUT,
    ST_STEP,
    ST_PUT_PTR,
    ST_PUT_CNT
  } seq_state_t;

  typedef struct packed {
    logic load_cnt;
    logic load_ptr;
    logic cap_dev;
    logic cap_mem;
    logic advance;
    logic load_ext;
  } ptr_ctl_t;

endpackage

// File: rtl/bxs_regs.sv
module bxs_regs
  import bxs_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ptr_ctl_t      ctl_i,
  input  logic [W-1:0]  mem_rdata_i,
  input  logic [W-1:0]  rx_data_i,
  input  logic [DW-1:0] dev_addr_i,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  ptr_o,
  output logic [W-1:0]  buf_o,
  output logic [DW-1:0] ext_o,
  output logic          last_word_o
);

  logic [W-1:0]  cnt_q, ptr_q, buf_q;
  logic [DW-1:0] ext_q;
  logic          last_word;

  // count wraps to zero on this step
  assign last_word = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      buf_q <= '0;
      ext_q <= '0;
    end else begin
      if (ctl_i.load_cnt)
        cnt_q <= mem_rdata_i;
      else if (ctl_i.advance)
        cnt_q <= cnt_q + W'(1);

      // pre-increment at load; after the last word the pointer stays on it
      if (ctl_i.load_ptr)
        ptr_q <= mem_rdata_i + W'(1);
      else if (ctl_i.advance && !last_word)
        ptr_q <= ptr_q + W'(1);

      if (ctl_i.cap_dev)
        buf_q <= rx_data_i;
      else if (ctl_i.cap_mem)
        buf_q <= mem_rdata_i;

      if (ctl_i.load_ext)
        ext_q <= dev_addr_i;
      else if (ctl_i.advance)
        ext_q <= ext_q + DW'(1);
    end
  end

  assign cnt_o       = cnt_q;
  assign ptr_o       = ptr_q;
  assign buf_o       = buf_q;
  assign ext_o       = ext_q;
  assign last_word_o = last_word;

endmodule

// File: rtl/bxs_fsm.sv
module bxs_fsm
  import bxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dir_wr_i,
  input  logic       mem_done_i,
  input  logic       rx_valid_i,
  input  logic       tx_ready_i,
  input  logic       last_word_i,
  output seq_state_t state_o,
  output ptr_ctl_t   ctl_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       rx_ready_o,
  output logic       tx_valid_o,
  output logic       busy_o,
  output logic       done_o
);

  seq_state_t state_q, state_d;
  logic       dir_q;
  logic       done_q;
  logic       accept;
  logic       finish;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign finish = (state_q == ST_PUT_CNT) && mem_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)     state_d = ST_GET_CNT;
      ST_GET_CNT: if (mem_done_i)  state_d = ST_GET_PTR;
      ST_GET_PTR: if (mem_done_i)  state_d = dir_q ? ST_MEM_GET : ST_DEV_IN;
      ST_DEV_IN:  if (rx_valid_i)  state_d = ST_MEM_PUT;
      ST_MEM_PUT: if (mem_done_i)  state_d = ST_STEP;
      ST_MEM_GET: if (mem_done_i)  state_d = ST_DEV_OUT;
      ST_DEV_OUT: if (tx_ready_i)  state_d = ST_STEP;
      ST_STEP:    state_d = last_word_i ? ST_PUT_PTR
                                        : (dir_q ? ST_MEM_GET : ST_DEV_IN);
      ST_PUT_PTR: if (mem_done_i)  state_d = ST_PUT_CNT;
      ST_PUT_CNT: if (mem_done_i)  state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) dir_q <= dir_wr_i;
      if (finish)      done_q <= 1'b1;
      else if (accept) done_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o.load_cnt = (state_q == ST_GET_CNT) && mem_done_i;
    ctl_o.load_ptr = (state_q == ST_GET_PTR) && mem_done_i;
    ctl_o.cap_dev  = (state_q == ST_DEV_IN)  && rx_valid_i;
    ctl_o.cap_mem  = (state_q == ST_MEM_GET) && mem_done_i;
    ctl_o.advance  = (state_q == ST_STEP);
    ctl_o.load_ext = accept;
  end

  assign mem_rd_o   = (state_q == ST_GET_CNT) || (state_q == ST_GET_PTR) ||
                      (state_q == ST_MEM_GET);
  assign mem_wr_o   = (state_q == ST_MEM_PUT) || (state_q == ST_PUT_PTR) ||
                      (state_q == ST_PUT_CNT);
  assign rx_ready_o = (state_q == ST_DEV_IN);
  assign tx_valid_o = (state_q == ST_DEV_OUT);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign state_o    = state_q;

  assert_rx_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready_o && !rx_valid_i) |=> (rx_ready_o && !mem_rd_o && !mem_wr_o));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o);

  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (state_q != ST_GET_CNT || $past(state_q) == ST_GET_CNT));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int unsigned         WORD_W  = 12,
  parameter int unsigned         EXT_W   = 8,
  parameter logic [WORD_W-1:0]   CNT_LOC = 12'o7750
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      dir_wr_i,
  input  logic [EXT_W+WORD_W-1:0]   dev_addr_i,
  output logic                      mem_rd_o,
  output logic                      mem_wr_o,
  output logic [WORD_W-1:0]         mem_addr_o,
  output logic [WORD_W-1:0]         mem_wdata_o,
  input  logic [WORD_W-1:0]         mem_rdata_i,
  input  logic                      mem_done_i,
  input  logic                      dev_rx_valid_i,
  input  logic [WORD_W-1:0]         dev_rx_data_i,
  output logic                      dev_rx_ready_o,
  output logic                      dev_tx_valid_o,
  output logic [WORD_W-1:0]         dev_tx_data_o,
  input  logic                      dev_tx_ready_i,
  output logic [EXT_W+WORD_W-1:0]   dev_addr_o,
  output logic                      busy_o,
  output logic                      done_o
);

  localparam int unsigned       DEV_W   = EXT_W + WORD_W;
  localparam logic [WORD_W-1:0] PTR_LOC = CNT_LOC + WORD_W'(1);

  seq_state_t          state;
  ptr_ctl_t            ctl;
  logic [WORD_W-1:0]   cnt, ptr, wbuf;
  logic                last_word;

  bxs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dir_wr_i    (dir_wr_i),
    .mem_done_i  (mem_done_i),
    .rx_valid_i  (dev_rx_valid_i),
    .tx_ready_i  (dev_tx_ready_i),
    .last_word_i (last_word),
    .state_o     (state),
    .ctl_o       (ctl),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .rx_ready_o  (dev_rx_ready_o),
    .tx_valid_o  (dev_tx_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  bxs_regs #(.W(WORD_W), .DW(DEV_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_i       (ctl),
    .mem_rdata_i (mem_rdata_i),
    .rx_data_i   (dev_rx_data_i),
    .dev_addr_i  (dev_addr_i),
    .cnt_o       (cnt),
    .ptr_o       (ptr),
    .buf_o       (wbuf),
    .ext_o       (dev_addr_o),
    .last_word_o (last_word)
  );

  always_comb begin
    unique case (state)
      ST_GET_CNT, ST_PUT_CNT: mem_addr_o = CNT_LOC;
      ST_GET_PTR, ST_PUT_PTR: mem_addr_o = PTR_LOC;
      default:                mem_addr_o = ptr;
    endcase
    unique case (state)
      ST_PUT_PTR: mem_wdata_o = ptr;
      ST_PUT_CNT: mem_wdata_o = cnt;
      default:    mem_wdata_o = wbuf;
    endcase
  end

  assign dev_tx_data_o = wbuf;

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_o || mem_wr_o) && !mem_done_i) |=>
      (mem_rd_o == $past(mem_rd_o)) && (mem_wr_o == $past(mem_wr_o)) &&
      $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_done_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_wr_o && mem_done_i && (mem_addr_o == CNT_LOC)));

  assert_tx_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid_o && !dev_tx_ready_i) |=> $stable(dev_tx_data_o));

endmodule

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;

  localparam logic [11:0] CNT = 12'o7750;
  localparam logic [11:0] PTR = 12'o7751;

  typedef struct packed {
    logic        dir;
    logic [4:0]  n;
    logic [11:0] base;
    logic [19:0] dev;
    logic [1:0]  lat;
    logic [1:0]  stall;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 5'd4,  12'o0777, 20'h00010, 2'd1, 2'd0},
    '{1'b1, 5'd5,  12'o1000, 20'h12345, 2'd2, 2'd1},
    '{1'b0, 5'd1,  12'o3777, 20'h00000, 2'd0, 2'd2},
    '{1'b1, 5'd3,  12'o7776, 20'hFFFFE, 2'd1, 2'd0},
    '{1'b0, 5'd7,  12'o7776, 20'h0FFFF, 2'd3, 2'd3},
    '{1'b1, 5'd16, 12'o2000, 20'h00100, 2'd0, 2'd0}
  };

  logic        clk, rst_n, start_i, dir_wr_i;
  logic [19:0] dev_addr_i, dev_addr_o;
  logic        mem_rd_o, mem_wr_o, mem_done_i;
  logic [11:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        dev_rx_valid_i, dev_rx_ready_o, dev_tx_valid_o, dev_tx_ready_i;
  logic [11:0] dev_rx_data_i, dev_tx_data_o;
  logic        busy_o, done_o;

  blk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
    .dev_addr_i(dev_addr_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_done_i(mem_done_i), .dev_rx_valid_i(dev_rx_valid_i),
    .dev_rx_data_i(dev_rx_data_i), .dev_rx_ready_o(dev_rx_ready_o),
    .dev_tx_valid_o(dev_tx_valid_o), .dev_tx_data_o(dev_tx_data_o),
    .dev_tx_ready_i(dev_tx_ready_i), .dev_addr_o(dev_addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks, n_fail;
  int lat_cfg, stall_cfg;
  logic hold_rx;
  int fill_req, fill_ack;
  logic [11:0] cfg_cnt, cfg_ptr;

  logic [11:0] mem [4096];
  int          tr_n, wait_cnt, early_done;
  logic [11:0] tr_addr [512];
  logic        tr_wr   [512];
  int          rx_idx, rx_hold;
  logic        rx_fire;
  int          tx_idx, tx_hold;
  logic [11:0] tx_got  [256];

  function automatic logic [11:0] rx_word(input int i);
    return 12'((i * 12'h2B7) + 12'h1C3);
  endfunction

  function automatic logic [11:0] pre_val(input logic [11:0] a);
    return a ^ 12'o5252;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: serves requests at negedges, logs every completed access
  initial begin
    mem_done_i = 1'b0; mem_rdata_i = '0; wait_cnt = 0; tr_n = 0;
    early_done = 0; fill_ack = 0;
    forever begin
      @(negedge clk);
      mem_done_i = 1'b0;
      if (fill_ack != fill_req) begin
        for (int a = 0; a < 4096; a++) mem[a] = pre_val(12'(a));
        mem[CNT] = cfg_cnt;
        mem[PTR] = cfg_ptr;
        fill_ack = fill_req;
      end
      if (!rst_n || !(mem_rd_o || mem_wr_o)) wait_cnt = 0;
      else if (wait_cnt >= lat_cfg) begin
        wait_cnt = 0;
        mem_done_i = 1'b1;
        if (mem_rd_o) mem_rdata_i = mem[mem_addr_o];
        else begin
          if (mem_addr_o == CNT && done_o) early_done++;
          mem[mem_addr_o] = mem_wdata_o;
        end
        tr_addr[tr_n % 512] = mem_addr_o;
        tr_wr[tr_n % 512]   = mem_wr_o;
        tr_n++;
      end else wait_cnt++;
    end
  end

  // device source model
  initial begin
    dev_rx_valid_i = 1'b0; dev_rx_data_i = '0; rx_idx = 0; rx_hold = 0; rx_fire = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_fire) begin rx_idx++; rx_hold = stall_cfg; rx_fire = 1'b0; end
      if (hold_rx || rx_hold > 0) begin
        dev_rx_valid_i = 1'b0;
        if (rx_hold > 0) rx_hold--;
      end else begin
        dev_rx_valid_i = 1'b1;
        dev_rx_data_i  = rx_word(rx_idx);
      end
      if (dev_rx_valid_i && dev_rx_ready_o && rst_n) rx_fire = 1'b1;
    end
  end

  // device sink model
  initial begin
    dev_tx_ready_i = 1'b0; tx_idx = 0; tx_hold = 0;
    forever begin
      @(negedge clk);
      if (tx_hold > 0) begin dev_tx_ready_i = 1'b0; tx_hold--; end
      else dev_tx_ready_i = 1'b1;
      if (dev_tx_valid_o && dev_tx_ready_i && rst_n) begin
        tx_got[tx_idx % 256] = dev_tx_data_o;
        tx_idx++;
        tx_hold = stall_cfg;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  task automatic fill_mem(input logic [11:0] c, input logic [11:0] p);
    cfg_cnt = c; cfg_ptr = p;
    fill_req++;
    while (fill_ack != fill_req) @(negedge clk);
  endtask

  task automatic do_start(input logic d, input logic [19:0] a);
    @(negedge clk);
    start_i = 1'b1; dir_wr_i = d; dev_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    while (!done_o && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic check_idle(input string what);
    check(!busy_o && !done_o && !mem_rd_o && !mem_wr_o && !dev_rx_ready_o && !dev_tx_valid_o,
          "R1", what, {busy_o, done_o, mem_rd_o, mem_wr_o, dev_rx_ready_o, dev_tx_valid_o}, 0);
  endtask

  task automatic run_vec(input vec_t t, input bit poke);
    int tr0, rx0, tx0, e0, n;
    logic bad_a, bad_d;
    logic [11:0] a;
    n = int'(t.n);
    lat_cfg = int'(t.lat); stall_cfg = int'(t.stall);
    fill_mem(12'(-n), t.base);
    tr0 = tr_n; rx0 = rx_idx; tx0 = tx_idx; e0 = early_done;
    do_start(t.dir, t.dev);
    check(busy_o && !done_o, "R8", "busy set and done cleared after start", {busy_o, done_o}, 2);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1; dir_wr_i = ~t.dir; dev_addr_i = 20'hABCDE;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    check(tr_addr[tr0 % 512] == CNT && !tr_wr[tr0 % 512], "R2", "first access reads count",
          tr_addr[tr0 % 512], CNT);
    check(tr_addr[(tr0 + 1) % 512] == PTR && !tr_wr[(tr0 + 1) % 512], "R2",
          "second access reads pointer", tr_addr[(tr0 + 1) % 512], PTR);
    check(tr_n - tr0 == n + 4, "R6", "access count", tr_n - tr0, n + 4);
    bad_a = 1'b0; bad_d = 1'b0;
    for (int i = 0; i < n; i++) begin
      a = 12'(t.base + 12'(1 + i));
      if (tr_addr[(tr0 + 2 + i) % 512] != a || tr_wr[(tr0 + 2 + i) % 512] != !t.dir) bad_a = 1'b1;
      if (!t.dir && mem[a] != rx_word(rx0 + i)) bad_d = 1'b1;
      if (t.dir && tx_got[(tx0 + i) % 256] != pre_val(a)) bad_d = 1'b1;
    end
    check(!bad_a, "R3", "data addresses from pointer plus one", bad_a, 0);
    if (t.dir) begin
      check(!bad_d, "R5", "words delivered to device", bad_d, 0);
      check(tx_idx - tx0 == n, "R5", "device word count", tx_idx - tx0, n);
    end else begin
      check(!bad_d, "R4", "device words stored in memory", bad_d, 0);
      check(rx_idx - rx0 == n, "R4", "device words taken", rx_idx - rx0, n);
    end
    check(tr_addr[(tr0 + n + 2) % 512] == PTR && tr_wr[(tr0 + n + 2) % 512], "R7",
          "pointer written back first", tr_addr[(tr0 + n + 2) % 512], PTR);
    check(tr_addr[(tr0 + n + 3) % 512] == CNT && tr_wr[(tr0 + n + 3) % 512], "R7",
          "count written back last", tr_addr[(tr0 + n + 3) % 512], CNT);
    check(mem[PTR] == 12'(t.base + 12'(n)), "R7", "pointer value", mem[PTR], 12'(t.base + 12'(n)));
    check(mem[CNT] == 12'd0, "R7", "count value", mem[CNT], 0);
    check(early_done == e0, "R8", "done not raised before count write-back", early_done - e0, 0);
    check(done_o && !busy_o, "R8", "done and idle at end", {done_o, busy_o}, 2);
    check(dev_addr_o == 20'(t.dev + 20'(n)), "R9", "device address", dev_addr_o, 20'(t.dev + 20'(n)));
    repeat (5) @(negedge clk);
    check(done_o && !mem_rd_o && !mem_wr_o, "R8", "done sticky while idle",
          {done_o, mem_rd_o, mem_wr_o}, 4);
  endtask

  initial begin
    int tr0, rx0;
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; dir_wr_i = 1'b0; dev_addr_i = '0;
    lat_cfg = 0; stall_cfg = 0; hold_rx = 1'b0; fill_req = 0; cfg_cnt = '0; cfg_ptr = '0;
    repeat (3) @(negedge clk);
    check_idle("outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("outputs after reset release");

    // table walk; vector 1 also gets a second start while busy (R12)
    for (int v = 0; v < 6; v++) run_vec(VECS[v], v == 1);

    // R11: device withholds data, sequencer must wait
    lat_cfg = 0; stall_cfg = 0; hold_rx = 1'b1;
    fill_mem(12'o7776, 12'o0100);
    tr0 = tr_n; rx0 = rx_idx;
    do_start(1'b0, 20'h00000);
    repeat (60) @(negedge clk);
    check(busy_o && dev_rx_ready_o && (tr_n - tr0 == 2), "R11", "waits for device data",
          tr_n - tr0, 2);
    hold_rx = 1'b0;
    wait_done();
    check(mem[12'o0101] == rx_word(rx0) && mem[12'o0102] == rx_word(rx0 + 1), "R11",
          "completes after stall", mem[12'o0101], rx_word(rx0));

    // R1: reset in the middle of a transfer
    lat_cfg = 1;
    fill_mem(12'o7773, 12'o0400);
    do_start(1'b1, 20'h00000);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("reset during transfer");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("idle after mid-transfer reset");
    run_vec(VECS[0], 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule